// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a 14-bit virtual address into a 12-bit physical address by looking up one entry of a single-level page table kept in external memory. A requester presents the virtual address together with an access kind (read or write) and a privilege flag (user or supervisor). The block adds twice the virtual page number to a page-table base supplied on an input port. It issues exactly one read on a simple request/response memory port and decodes the returned 16-bit entry. It then answers with either the physical address or a fault status.

The low six address bits select a byte within a 64-byte page and are copied straight through. The upper eight virtual bits index the table, and the entry supplies the six-bit physical page number. Only one translation is in flight at a time. The requester must take the response before a new request is accepted.

Top module: `pt_xlate_top`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: On success the physical address is the entry's page number in bits 11..6, with bits 5..0 equal to bits 5..0 of the virtual address.
- R3: Each accepted request causes exactly one memory read. Its address is `pt_base + 2 * vaddr[13:6]`, taken modulo 2^16, using the base sampled when the request is accepted.
- R4: The 16-bit entry is decoded as follows: bit 15 is present, bit 14 is read allowed, bit 13 is write allowed, bit 12 is supervisor-only, and bits 5..0 are the physical page number. Bits 11..6 are ignored.
- R5: An entry whose present bit is 0 yields status 01 (page fault), whatever its permission bits say.
- R6: A write to a present page whose write-allowed bit is 0 yields status 10 (protection fault).
- R7: A user access (`req_user`=1) to a present page marked supervisor-only yields status 10. A supervisor access to that page is translated normally.
- R8: A read of a present page whose read-allowed bit is 0 yields status 10.
- R9: Status 00 means success. Status 11 never occurs. When the status is not 00, `rsp_paddr` is 0.
- R10: From the acceptance of a request until its response is taken, `req_ready` is 0 and any request presented is ignored: it produces no memory read and no response.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, the response and its fields hold steady.
- R12: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the memory request and its address hold steady.
- R13: Take a base of 0x0100 and an entry for page 0x0D that is present, readable and has page number 0x2D. A read of virtual address 0x0354 then returns physical address 0xB54, which is page 0x2D with offset 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_base | input | 16 | Byte address of the current page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 14 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 12 | Physical address, zero on fault |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| mem_req_valid | output | 1 | Entry read request present |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 16 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned (one cycle) |
| mem_rsp_data | input | 16 | Entry word |

## Verification
The bench goes after fault priority with a non-present entry whose permission bits would also deny the access. A design that checked permissions first would report a protection fault there instead of a page fault. It also probes each permission bit alone, including a page that is write-only, so a swapped read/write bit or a supervisor test applied to the wrong privilege shows up as a wrong status. Page numbers 0x00 and 0xFF, and a base near the top of memory that wraps, expose entry-address arithmetic that shifts by the wrong amount or truncates. A requester that keeps asking while the block is busy, a memory that stalls and answers late, and a response held off by the requester catch a block that accepts a second request, drops its memory address, or lets its response change.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

    localparam int VA_W      = 14;
    localparam int PA_W      = 12;
    localparam int OFF_W     = 6;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int PPN_W     = PA_W - OFF_W;
    localparam int MEM_AW    = 16;
    localparam int PTE_W     = 16;
    localparam int ENT_SHIFT = 1;   // entry is 2 bytes

    localparam int PTE_PRESENT_BIT = 15;
    localparam int PTE_READ_BIT    = 14;
    localparam int PTE_WRITE_BIT   = 13;
    localparam int PTE_SUPER_BIT   = 12;

    typedef enum logic [1:0] {
        XS_OK         = 2'b00,
        XS_PAGE_FAULT = 2'b01,
        XS_PROT_FAULT = 2'b10
    } xlate_status_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_REPLY
    } walk_state_e;

    typedef struct packed {
        logic             present;
        logic             can_read;
        logic             can_write;
        logic             super_only;
        logic [PPN_W-1:0] ppn;
    } pte_fields_t;

    typedef struct packed {
        logic [VA_W-1:0]   vaddr;
        logic              is_write;
        logic              is_user;
        logic [MEM_AW-1:0] base;
    } xlate_req_t;

    typedef struct packed {
        logic [PA_W-1:0] paddr;
        xlate_status_e   status;
    } xlate_rsp_t;

    function automatic logic access_denied(input pte_fields_t f,
                                           input logic wr,
                                           input logic usr);
        return (wr && !f.can_write) || (!wr && !f.can_read) || (usr && f.super_only);
    endfunction

endpackage

// File: rtl/pt_addr_split.sv
module pt_addr_split
    import pt_xlate_pkg::*;
#(
    parameter int P_VA_W      = VA_W,
    parameter int P_OFF_W     = OFF_W,
    parameter int P_MEM_AW    = MEM_AW,
    parameter int P_ENT_SHIFT = ENT_SHIFT
) (
    input  logic [P_VA_W-1:0]          vaddr,
    input  logic [P_MEM_AW-1:0]        base,
    output logic [P_VA_W-P_OFF_W-1:0]  vpn,
    output logic [P_OFF_W-1:0]         offset,
    output logic [P_MEM_AW-1:0]        entry_addr
);
    localparam int L_VPN_W = P_VA_W - P_OFF_W;
    localparam int L_PAD_W = P_MEM_AW - L_VPN_W - P_ENT_SHIFT;

    logic [P_MEM_AW-1:0] scaled_vpn;

    assign vpn    = vaddr[P_VA_W-1:P_OFF_W];
    assign offset = vaddr[P_OFF_W-1:0];

    generate
        if (P_ENT_SHIFT > 0) begin : g_scaled
            assign scaled_vpn = {{L_PAD_W{1'b0}}, vpn, {P_ENT_SHIFT{1'b0}}};
        end else begin : g_unscaled
            assign scaled_vpn = {{L_PAD_W{1'b0}}, vpn};
        end
    endgenerate

    assign entry_addr = base + scaled_vpn;
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
    import pt_xlate_pkg::*;
(
    input  logic [PTE_W-1:0] pte_word,
    input  logic [OFF_W-1:0] offset,
    input  logic             is_write,
    input  logic             is_user,
    output xlate_rsp_t       result
);
    pte_fields_t fields;
    logic        unused_rsvd;

    assign fields.present    = pte_word[PTE_PRESENT_BIT];
    assign fields.can_read   = pte_word[PTE_READ_BIT];
    assign fields.can_write  = pte_word[PTE_WRITE_BIT];
    assign fields.super_only = pte_word[PTE_SUPER_BIT];
    assign fields.ppn        = pte_word[PPN_W-1:0];
    assign unused_rsvd       = ^pte_word[PTE_SUPER_BIT-1:PPN_W];

    always_comb begin
        result = '{paddr: '0, status: XS_OK};
        if (!fields.present) begin
            result.status = XS_PAGE_FAULT;
        end else if (access_denied(fields, is_write, is_user)) begin
            result.status = XS_PROT_FAULT;
        end else begin
            result.paddr = {fields.ppn, offset};
        end
    end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
    import pt_xlate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic rsp_ready,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    output logic req_ready,
    output logic mem_req_valid,
    output logic rsp_valid,
    output logic capture_en,
    output logic result_en
);
    walk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)     state_d = ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_REPLY;
            ST_REPLY: if (rsp_ready)     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_ISSUE);
    assign rsp_valid     = (state_q == ST_REPLY);
    assign capture_en    = req_ready && req_valid;
    assign result_en     = (state_q == ST_WAIT) && mem_rsp_valid;
endmodule

// File: rtl/pt_xlate_top.sv
module pt_xlate_top
    import pt_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MEM_AW-1:0] pt_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_status,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data
);
    xlate_req_t        req_q;
    xlate_rsp_t        rsp_q;
    xlate_rsp_t        check_res;
    logic              capture_en;
    logic              result_en;
    logic [VPN_W-1:0]  vpn;
    logic [OFF_W-1:0]  offset;
    logic [MEM_AW-1:0] entry_addr;
    logic              unused_vpn;

    pt_walk_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .rsp_ready     (rsp_ready),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .rsp_valid     (rsp_valid),
        .capture_en    (capture_en),
        .result_en     (result_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (capture_en) begin
            req_q <= '{vaddr: req_vaddr, is_write: req_write,
                       is_user: req_user, base: pt_base};
        end
    end

    pt_addr_split u_split (
        .vaddr      (req_q.vaddr),
        .base       (req_q.base),
        .vpn        (vpn),
        .offset     (offset),
        .entry_addr (entry_addr)
    );

    assign unused_vpn   = ^vpn;
    assign mem_req_addr = entry_addr;

    pt_perm_check u_perm (
        .pte_word (mem_rsp_data),
        .offset   (offset),
        .is_write (req_q.is_write),
        .is_user  (req_q.is_user),
        .result   (check_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '{paddr: '0, status: XS_OK};
        end else if (result_en) begin
            rsp_q <= check_res;
        end
    end

    assign rsp_paddr  = rsp_q.paddr;
    assign rsp_status = rsp_q.status;
endmodule

// File: rtl/pt_xlate_checker.sv
module pt_xlate_checker
    import pt_xlate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [MEM_AW-1:0] pt_base,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [1:0]        rsp_status,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [MEM_AW-1:0] mem_req_addr
);
    logic [VA_W-1:0]   seen_vaddr;
    logic [MEM_AW-1:0] seen_base;
    logic [MEM_AW-1:0] want_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_vaddr <= '0;
            seen_base  <= '0;
        end else if (req_valid && req_ready) begin
            seen_vaddr <= req_vaddr;
            seen_base  <= pt_base;
        end
    end

    assign want_addr = seen_base + (MEM_AW'(seen_vaddr[VA_W-1:OFF_W]) << ENT_SHIFT);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !mem_req_valid));

    assert_offset_passes_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'b00) |-> rsp_paddr[OFF_W-1:0] == seen_vaddr[OFF_W-1:0]);

    assert_entry_addr_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_addr == want_addr);

    assert_fault_zero_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 2'b00) |-> rsp_paddr == '0);

    assert_no_status3_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_status != 2'b11);

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_accept_while_reply_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || mem_req_valid) |-> !req_ready);

    assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_status)));

    assert_mem_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind pt_xlate_top pt_xlate_checker chk_i (
    .clk           (clk),
    .rst           (rst),
    .pt_base       (pt_base),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_status    (rsp_status),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/pt_xlate_top_tb_top.sv
module pt_xlate_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pt_base = 16'h0100;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [11:0] rsp_paddr;
    logic [1:0]  rsp_status;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rsp_data = '0;

    always #10ns clk = ~clk;

    pt_xlate_top dut_i (
        .clk(clk), .rst(rst), .pt_base(pt_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_status(rsp_status),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rsp_count = 0;
    int mem_lat = 0;
    bit mem_stall = 0;
    bit busy = 0;
    string cur_tag = "R2";

    logic [15:0] pmem [int];
    int    exp_pa[$];
    int    exp_st[$];
    int    exp_ma[$];
    string exp_tag[$];

    bit          macc = 0;
    int          maddr_q = 0;
    bit          mpend = 0;
    int          mcnt = 0;
    bit          rsp_hold_prev = 0;
    logic [11:0] prev_pa = '0;
    logic [1:0]  prev_st = '0;
    bit          mreq_hold_prev = 0;
    logic [15:0] prev_ma = '0;

    int          m_ea, m_st, m_pa;
    logic [15:0] m_e;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_mem(input int a);
        return pmem.exists(a) ? pmem[a] : 16'h0000;
    endfunction

    // Behavioural reference: predicts each response from the table and the request.
    always @(posedge clk) begin
        cyc++;
        macc = 0;
        if (rst) begin
            busy = 0;
            rsp_hold_prev = 0;
            mreq_hold_prev = 0;
            exp_pa.delete(); exp_st.delete(); exp_ma.delete(); exp_tag.delete();
        end else begin
            rsp_hold_prev  = rsp_valid && !rsp_ready;
            prev_pa        = rsp_paddr;
            prev_st        = rsp_status;
            mreq_hold_prev = mem_req_valid && !mem_req_ready;
            prev_ma        = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                macc = 1;
                maddr_q = int'(mem_req_addr);
            end
            if (req_valid && req_ready) begin
                m_ea = (int'(pt_base) + int'(req_vaddr[13:6]) * 2) % 65536;
                m_e  = rd_mem(m_ea);
                if (!m_e[15])
                    m_st = 1;
                else if ((req_write && !m_e[13]) || (!req_write && !m_e[14]) || (req_user && m_e[12]))
                    m_st = 2;
                else
                    m_st = 0;
                m_pa = (m_st == 0) ? (int'(m_e[5:0]) * 64 + int'(req_vaddr[5:0])) : 0;
                exp_pa.push_back(m_pa);
                exp_st.push_back(m_st);
                exp_ma.push_back(m_ea);
                exp_tag.push_back(cur_tag);
                busy = 1;
            end
            if (rsp_valid && rsp_ready) begin
                if (exp_pa.size() == 0) begin
                    check(0, "R10", "unexpected response", 1, 0);
                end else begin
                    check(int'(rsp_paddr) == exp_pa[0], exp_tag[0], "rsp_paddr", rsp_paddr, exp_pa[0]);
                    check(int'(rsp_status) == exp_st[0], exp_tag[0], "rsp_status", rsp_status, exp_st[0]);
                    void'(exp_pa.pop_front()); void'(exp_st.pop_front()); void'(exp_tag.pop_front());
                end
                busy = 0;
                rsp_count++;
            end
        end
    end

    // Per-cycle compare and memory model.
    always @(negedge clk) begin
        if (!rst) begin
            check(req_ready == !busy, "R10", "req_ready", req_ready, !busy);
            if (rsp_hold_prev)
                check(rsp_valid && rsp_paddr == prev_pa && rsp_status == prev_st,
                      "R11", "held response", rsp_paddr, prev_pa);
            if (mreq_hold_prev)
                check(mem_req_valid && mem_req_addr == prev_ma,
                      "R12", "held mem request", mem_req_addr, prev_ma);
        end
        mem_rsp_valid = 1'b0;
        if (macc) begin
            if (exp_ma.size() == 0) begin
                check(0, "R10", "unexpected mem read", maddr_q, 0);
            end else begin
                check(maddr_q == exp_ma[0], "R3", "mem_req_addr", maddr_q, exp_ma[0]);
                void'(exp_ma.pop_front());
            end
            mpend = 1;
            mcnt  = mem_lat;
        end
        if (mpend) begin
            if (mcnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd_mem(maddr_q);
                mpend = 0;
            end else begin
                mcnt--;
            end
        end
        mem_req_ready = mem_stall ? (cyc % 3 == 2) : 1'b1;
    end

    task automatic xlate(input logic [13:0] va, input bit wr, input bit usr,
                         input string tag, input int hold, input bit pester);
        int n0;
        @(negedge clk);
        cur_tag   = tag;
        req_vaddr = va;
        req_write = wr;
        req_user  = usr;
        req_valid = 1'b1;
        do @(posedge clk); while (!req_ready);
        n0 = rsp_count;
        @(negedge clk);
        if (pester) begin
            req_vaddr = va ^ 14'h2AC0;
            req_write = !wr;
        end else begin
            req_valid = 1'b0;
        end
        if (hold > 0) begin
            rsp_ready = 1'b0;
            repeat (hold) @(negedge clk);
            rsp_ready = 1'b1;
        end
        while (rsp_count == n0) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog R10 actual=0x%0h expected=0x%0h", rsp_count, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // table at base 0x0100, 2-byte entries
        pmem[16'h0100 + 2*8'h0D] = 16'hE02D; // present, R, W, page 0x2D
        pmem[16'h0100 + 2*8'h02] = 16'hC033; // present, R only, page 0x33
        pmem[16'h0100 + 2*8'h05] = 16'hF016; // present, R, W, supervisor-only
        pmem[16'h0100 + 2*8'h04] = 16'h603F; // not present, R, W
        pmem[16'h0100 + 2*8'h09] = 16'hA017; // present, W only
        pmem[16'h0100 + 2*8'hFF] = 16'hEFFF; // present, R, W, reserved bits set, page 0x3F
        pmem[16'h0100]           = 16'hE028; // page 0x00 -> 0x28
        pmem[16'h000A]           = 16'hE001; // wrapped table entry

        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", mem_req_valid, 0);
        rst = 1'b0;

        xlate(14'h0354, 0, 0, "R13", 0, 0);          // -> 0xB54
        xlate(14'h037F, 1, 1, "R2", 0, 0);           // -> 0xB7F
        xlate(14'h0085, 0, 1, "R4", 0, 0);           // read-only page read -> 0xCC5
        xlate(14'h0085, 1, 0, "R6", 0, 0);           // write to read-only -> prot
        xlate(14'h0161, 0, 1, "R7", 0, 0);           // user on supervisor page -> prot
        xlate(14'h0161, 1, 0, "R7", 0, 0);           // supervisor -> 0x5A1
        xlate(14'h0107, 0, 0, "R5", 0, 0);           // not present -> page fault
        xlate(14'h0107, 1, 1, "R5", 0, 0);           // page fault wins over permissions
        xlate(14'h0250, 0, 0, "R8", 0, 0);           // read of write-only -> prot
        xlate(14'h0250, 1, 0, "R8", 0, 0);           // write ok -> 0x5D0
        xlate(14'h3FFF, 0, 0, "R4", 0, 0);           // reserved bits ignored, top page -> 0xFFF
        xlate(14'h0000, 1, 0, "R3", 0, 0);           // page 0 -> 0xA00
        xlate(14'h0085, 1, 1, "R9", 0, 0);           // fault address is zero

        mem_lat = 2;
        mem_stall = 1;
        xlate(14'h0354, 0, 0, "R12", 6, 0);
        xlate(14'h0161, 0, 1, "R11", 8, 0);
        xlate(14'h0250, 1, 0, "R11", 5, 0);
        mem_lat = 0;
        mem_stall = 0;

        xlate(14'h0354, 0, 0, "R10", 3, 1);          // requester keeps asking while busy
        repeat (4) @(negedge clk);
        check(rsp_valid == 1'b0 && exp_pa.size() == 0, "R10", "ignored request leaked",
              exp_pa.size(), 0);

        pt_base = 16'hFFF0;                          // 0xFFF0 + 0x1A wraps to 0x000A
        xlate(14'h0354, 0, 0, "R3", 0, 0);           // -> 0x054
        pt_base = 16'h0100;

        repeat (4) @(negedge clk);
        check(exp_pa.size() == 0 && exp_ma.size() == 0, "R3", "outstanding expectations",
              exp_pa.size() + exp_ma.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule